// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an internal valid/ready request bus and an external byte-wide asynchronous static RAM with 19 address bits. A request carries a direction flag, an address and, for writes, a data byte. The controller turns it into the active-low chip-select, output-enable and write-strobe sequence the memory expects. It drives the shared data pins through a separate output, output-enable and input trio, so the pad ring can build the tri-state buffer.

Every analog timing limit is a nanosecond parameter. At elaboration each limit is rounded up to whole clock cycles, using a clock-period parameter. Reads hold chip-select and output-enable low until the slowest of the address, select and output-enable access times has elapsed. The returned byte is then registered. Writes are strobe-controlled: chip-select and address settle first with output-enable high, then the write strobe pulses low while the controller drives data. The strobe's rising edge ends the write. Data drive stops on that same edge, and it only starts once the memory can no longer be driving the pins. Chip-select stays low across back-to-back requests. It is released whenever no request follows, which lets the memory drop into its own standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, sramCeN, sramOeN and sramWeN are 1, sramDqOe and rspValid are 0, and reqReady is 1.
- R2: A read holds sramCeN=0, sramOeN=0 and sramWeN=1 for RD = ceil(max(tAA, tACE, tDOE)/period) cycles (7 at 8 ns and 55/55/25 ns). The data pins are sampled at the end of that window. rspValid with that byte on rspRdata follows exactly RD cycles after the accepting edge.
- R3: A write holds sramCeN=0 and sramOeN=1 for its whole duration. sramWeN goes low after SET = max(1, ceil(tHZOE/period)) cycles and stays low for PUL = max(ceil(tPWE/period), ceil(tSD/period), ceil(tWC/period)-SET) cycles. The memory stores sramDqOut at sramAddr on the rising edge of sramWeN. The strobe pulse is at least 45 ns, data is driven at least 25 ns before that edge, and rspValid follows SET+PUL cycles after acceptance.
- R4: sramDqOe is 1 only while sramWeN is 0 in a write. It rises only after sramOeN has been 1 for at least tHZOE (25 ns), and it is 0 in the cycle sramWeN returns to 1. It is never 1 while sramOeN is 0.
- R5: Each accepted request produces exactly one rspValid pulse, one cycle wide. Pulses come in request order.
- R6: While requests follow one another with no gap, sramCeN stays 0 between accesses. When no request is accepted in the response cycle, sramCeN returns to 1 until the next acceptance.
- R7: reqReady is 1 only between accesses. Address, direction and data are captured on the accepting edge, so later changes on the request inputs have no effect. sramAddr is stable for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Word address |
| reqWdata | input | 8 | Write byte |
| rspValid | output | 1 | One-cycle completion pulse per request |
| rspRdata | output | 8 | Read byte (valid with rspValid after a read) |
| sramAddr | output | 19 | Memory address pins |
| sramCeN | output | 1 | Chip select, active low |
| sramOeN | output | 1 | Output enable, active low |
| sramWeN | output | 1 | Write strobe, active low |
| sramDqOut | output | 8 | Data to memory pins |
| sramDqOe | output | 1 | Drive enable for the data pins |
| sramDqIn | input | 8 | Data from memory pins |

## Verification
The hardest situation to reach is a read followed at once by a write to the same location. There the memory's output buffers have just been enabled, and the controller's data drive must wait out the turn-off time. The bench reaches it with an unbroken mixed stream: reqValid stays high while direction and address change in the response cycle. A memory model beside the bench returns a poison byte unless every access time has elapsed. The same model timestamps each edge of the select, enable and strobe lines, so any premature drive or short strobe is reported against the edge that caused it. Address tags in the model catch upper address bits that do not reach the pins.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;
  typedef struct packed {
    logic load;     // latch request fields
    logic capture;  // sample read data from pins
    logic drive;    // enable data pin drivers
  } ctrlStb_t;

  function automatic int ceilDiv(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS = 8,
  parameter int T_AA   = 55,
  parameter int T_ACE  = 55,
  parameter int T_DOE  = 25,
  parameter int T_HZOE = 25,
  parameter int T_PWE  = 45,
  parameter int T_SD   = 25,
  parameter int T_WC   = 55
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  output logic     reqReady,
  output logic     rspValid,
  output logic     ceN,
  output logic     oeN,
  output logic     weN,
  output ctrlStb_t stb
);
  localparam int RD_CYC  = maxOf(1, maxOf(maxOf(ceilDiv(T_AA, CLK_NS), ceilDiv(T_ACE, CLK_NS)),
                                          ceilDiv(T_DOE, CLK_NS)));
  localparam int SET_CYC = maxOf(1, ceilDiv(T_HZOE, CLK_NS));
  localparam int PUL_CYC = maxOf(1, maxOf(maxOf(ceilDiv(T_PWE, CLK_NS), ceilDiv(T_SD, CLK_NS)),
                                          ceilDiv(T_WC, CLK_NS) - SET_CYC));
  localparam int MAX_CYC = maxOf(RD_CYC, maxOf(SET_CYC, PUL_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WSET, ST_WPUL, ST_DONE} state_t;

  state_t     state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic       accept, cntZero;

  assign reqReady = (state == ST_IDLE) || (state == ST_DONE);
  assign accept   = reqValid && reqReady;
  assign cntZero  = (cnt == '0);

  always_comb begin
    stateNext = state;
    cntNext   = cntZero ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (accept) begin
          stateNext = reqWrite ? ST_WSET : ST_READ;
          cntNext   = reqWrite ? CNT_W'(SET_CYC - 1) : CNT_W'(RD_CYC - 1);
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_READ: if (cntZero) stateNext = ST_DONE;
      ST_WSET: if (cntZero) begin
        stateNext = ST_WPUL;
        cntNext   = CNT_W'(PUL_CYC - 1);
      end
      ST_WPUL: if (cntZero) stateNext = ST_DONE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign ceN         = (state == ST_IDLE);
  assign oeN         = (state != ST_READ);
  assign weN         = (state != ST_WPUL);
  assign rspValid    = (state == ST_DONE);
  assign stb.load    = accept;
  assign stb.capture = (state == ST_READ) && cntZero;
  assign stb.drive   = (state == ST_WPUL);
endmodule

// File: rtl/sram_ctrl_dp.sv
`timescale 1ns/1ps
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] sramDqIn,
  output logic [ADDR_W-1:0] sramAddr,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  output logic [DATA_W-1:0] rspRdata
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (stb.capture) rdataQ <= sramDqIn;
    end
  end

  assign sramAddr  = addrQ;
  assign sramDqOut = wdataQ;
  assign sramDqOe  = stb.drive;
  assign rspRdata  = rdataQ;
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int CLK_NS = 8,
  parameter int T_AA   = 55,
  parameter int T_ACE  = 55,
  parameter int T_DOE  = 25,
  parameter int T_HZOE = 25,
  parameter int T_PWE  = 45,
  parameter int T_SD   = 25,
  parameter int T_WC   = 55
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCeN,
  output logic              sramOeN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDqOut,
  output logic              sramDqOe,
  input  logic [DATA_W-1:0] sramDqIn
);
  ctrlStb_t stb;

  sram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .T_AA(T_AA), .T_ACE(T_ACE), .T_DOE(T_DOE),
    .T_HZOE(T_HZOE), .T_PWE(T_PWE), .T_SD(T_SD), .T_WC(T_WC)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .rspValid(rspValid),
    .ceN(sramCeN), .oeN(sramOeN), .weN(sramWeN), .stb(stb)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .sramDqIn(sramDqIn), .sramAddr(sramAddr), .sramDqOut(sramDqOut),
    .sramDqOe(sramDqOe), .rspRdata(rspRdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic [ADDR_W-1:0] sramAddr,
  input logic              sramCeN,
  input logic              sramOeN,
  input logic              sramWeN,
  input logic              sramDqOe
);
  p_strobe_oe_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> (sramOeN && !sramCeN));

  p_drive_in_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    sramDqOe |-> (!sramWeN && sramOeN));

  p_drive_off_at_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sramWeN) |-> !sramDqOe);

  p_rsp_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_idle_deselect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !rspValid) |-> sramCeN);

  p_addr_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!reqReady && $past(!reqReady)) |-> $stable(sramAddr));
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .sramAddr(sramAddr), .sramCeN(sramCeN), .sramOeN(sramOeN),
  .sramWeN(sramWeN), .sramDqOe(sramDqOe)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;
  localparam int PER = 8;
  localparam int RD  = (55 + PER - 1) / PER;
  localparam int SET = (25 + PER - 1) / PER;
  localparam int PW  = (45 + PER - 1) / PER;
  localparam int PUL = (PW > (55 + PER - 1) / PER - SET) ? PW : (55 + PER - 1) / PER - SET;

  logic clk = 1'b0;
  always #(PER / 2) clk = ~clk;

  logic rstN, reqValid, reqReady, reqWrite, rspValid;
  logic [18:0] reqAddr, sramAddr;
  logic [7:0]  reqWdata, rspRdata, sramDqOut, sramDqIn;
  logic sramCeN, sramOeN, sramWeN, sramDqOe;

  sram_ctrl u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .sramAddr(sramAddr),
    .sramCeN(sramCeN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramDqOut(sramDqOut), .sramDqOe(sramDqOe), .sramDqIn(sramDqIn)
  );

  int checks = 0, errors = 0, cyc = 0, ceRise = 0, drvBad = 0, resp = 0, sent = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory model with address tags and access-time enforcement
  logic [7:0]  mem [256];
  logic [10:0] tag [256];
  realtime tAddr = 0, tCeFall = 0, tOeFall = 0, tOeRise = -100, tWeFall = 0, tDrvOn = 0;
  logic lastDrv = 0, lastOe = 1;
  logic [7:0] lastDq = 0;

  initial for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; tag[i] = 11'h7ff; end

  always @(sramAddr) tAddr = $realtime;
  always @(negedge sramCeN) tCeFall = $realtime;
  always @(negedge sramOeN) tOeFall = $realtime;
  always @(posedge sramOeN) tOeRise = $realtime;
  always @(negedge sramWeN) tWeFall = $realtime;
  always @(posedge sramCeN) if ($realtime > 1) ceRise++;
  always @(posedge sramDqOe) begin
    tDrvOn = $realtime;
    chk(sramOeN === 1'b1 && ($realtime - tOeRise) >= 25.0, "R4", "OE high time before drive",
        int'($realtime - tOeRise), 25);
  end

  always @(posedge sramWeN) if (sramCeN === 1'b0) begin
    chk(($realtime - tWeFall) >= 45.0, "R3", "write strobe width ns", int'($realtime - tWeFall), 45);
    chk(lastDrv === 1'b1, "R4", "drive on at strobe end", int'(lastDrv), 1);
    chk(($realtime - tDrvOn) >= 25.0, "R3", "data setup ns", int'($realtime - tDrvOn), 25);
    chk(lastOe === 1'b1, "R3", "OE high during write", int'(lastOe), 1);
    mem[sramAddr[7:0]] = lastDq;
    tag[sramAddr[7:0]] = sramAddr[18:8];
  end

  initial begin
    sramDqIn = 8'hEE;
    #0.5;
    forever begin
      lastDrv = sramDqOe; lastDq = sramDqOut; lastOe = sramOeN;
      if (sramDqOe === 1'b1 && (sramWeN !== 1'b0 || sramOeN !== 1'b1)) drvBad++;
      if (sramCeN === 1'b0 && sramOeN === 1'b0 && sramWeN === 1'b1 &&
          ($realtime - ((tAddr > tCeFall) ? tAddr : tCeFall)) >= 55.0 &&
          ($realtime - tOeFall) >= 25.0)
        sramDqIn = (tag[sramAddr[7:0]] == sramAddr[18:8]) ? mem[sramAddr[7:0]] : 8'h5A;
      else
        sramDqIn = 8'hEE;
      #1;
    end
  end

  // expectation queues
  bit expWr[$];
  int expData[$];
  int expAcc[$];
  logic [7:0] refMem [256];

  always @(negedge clk) if (rstN === 1'b1 && rspValid === 1'b1) begin
    resp++;
    if (expWr.size() == 0) chk(0, "R5", "response without request", 1, 0);
    else begin
      bit w; int d, a;
      w = expWr.pop_front(); d = expData.pop_front(); a = expAcc.pop_front();
      chk(cyc - a == (w ? SET + PUL : RD), w ? "R3" : "R2", "response latency",
          cyc - a, w ? SET + PUL : RD);
      if (!w) chk(rspRdata == 8'(d), "R2", "read data (R7 capture)", rspRdata, d);
    end
  end

  function automatic logic [18:0] addrOf(input int i);
    return {11'((i * 37) ^ (i >> 3) ^ 11'h2a5), 8'(i)};
  endfunction

  task automatic send(input bit wr, input logic [18:0] a, input logic [7:0] d, input bit keep);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (reqReady !== 1'b1) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    sent++;
    if (wr) refMem[a[7:0]] = d;
    expWr.push_back(wr); expData.push_back(int'(refMem[a[7:0]])); expAcc.push_back(cyc);
    if (!keep) begin
      reqValid = 0; reqAddr = ~a; reqWdata = ~d; reqWrite = ~wr;  // R7: ignored after accept
    end
  endtask

  task automatic drain();
    while (expWr.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * PER);
    chk(0, "ALL", "watchdog expired", cyc, 0);
    finishRun();
  end

  initial begin
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0;
    repeat (3) @(negedge clk);
    chk(sramCeN === 1'b1, "R1", "CE after reset", int'(sramCeN), 1);
    chk(sramOeN === 1'b1, "R1", "OE after reset", int'(sramOeN), 1);
    chk(sramWeN === 1'b1, "R1", "WE after reset", int'(sramWeN), 1);
    chk(sramDqOe === 1'b0, "R1", "drive after reset", int'(sramDqOe), 0);
    chk(rspValid === 1'b0, "R1", "rspValid after reset", int'(rspValid), 0);
    chk(reqReady === 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    rstN = 1;
    @(negedge clk);

    // unbroken write burst over all 256 locations
    ceRise = 0;
    for (int i = 0; i < 256; i++) send(1, addrOf(i), 8'((i * 73 + 19) ^ (i >> 2)), i != 255);
    drain();
    chk(ceRise == 1, "R6", "CE releases in write burst", ceRise, 1);
    chk(sramCeN === 1'b1, "R6", "CE high when idle", int'(sramCeN), 1);

    // unbroken read burst
    ceRise = 0;
    for (int i = 0; i < 256; i++) send(0, addrOf(i), 8'h00, i != 255);
    drain();
    chk(ceRise == 1, "R6", "CE releases in read burst", ceRise, 1);

    // isolated requests with gaps
    ceRise = 0;
    for (int j = 0; j < 16; j++) begin
      send(1, addrOf(j * 5), 8'(j * 17 + 1), 0); drain();
      chk(reqReady === 1'b1 && sramCeN === 1'b1, "R6", "idle deselect between requests",
          int'(sramCeN), 1);
      send(0, addrOf(j * 5), 8'h00, 0); drain();
    end
    chk(ceRise == 32, "R6", "CE releases for isolated requests", ceRise, 32);

    // back-to-back read/write turnaround on the same locations
    for (int j = 0; j < 32; j++) begin
      send(0, addrOf(j), 8'h00, 1);
      send(1, addrOf(j), 8'(255 - j), 1);
      send(0, addrOf(j), 8'h00, j != 31);
    end
    drain();

    chk(resp == sent, "R5", "responses equal requests", resp, sent);
    chk(drvBad == 0, "R4", "drive outside strobe-low with OE high", drvBad, 0);
    finishRun();
  end
endmodule